// File: doc/BRIEF.md
# Transmit Buffer Command Parser and Packet Assembler

This block sits behind a 32-bit host write port that feeds outgoing frame data. The host writes a stream of words. Every buffer opens with a first command word (byte count, start offset, segment flags, completion-request flag, end-alignment mode), then a second command word whose upper half is a packet tag, then the data words. The block drops the leading offset bytes, unpacks the rest of the payload least significant byte first into a byte-addressed packet store, and swallows the alignment pad words that trail the data.

A frame may be spread over several buffers. Only the buffer flagged as the first segment loads the tag and restarts the packet length. When a buffer flagged as the last segment completes, the block raises a one-cycle send strobe that carries the byte length. It also queues the tag in a status FIFO, which the host drains through a pop input. One-cycle flags report a completion request, bytes lost to a full packet store, writes refused because the word budget is used up, a status FIFO that has just become full, and a status FIFO whose fill has risen above a programmable level.

Top module: `tx_pkt_assembler`

## Requirements
- R1: After reset the parser waits for a first command word, the status FIFO is empty, and sendValid and all five flags are low.
- R2: The first command word carries the byte count in bits 10:0, the start offset in bits 20:16, the last-segment flag in bit 12, the first-segment flag in bit 13, the alignment mode in bits 25:24 and the completion request in bit 31. The word after it is the second command word. When the final data or pad word of a last-segment buffer is written, sendValid is high for exactly the following cycle and sendLen gives the frame's byte length. No earlier write of the buffer produces a strobe.
- R3: Payload bytes are taken from each data word starting at bits 7:0. Whole words are discarded while four or more offset bytes remain, and the remaining offset bytes are dropped from the low end of the next word. Byte i of the frame is readable at pktRdAddr = i.
- R4: The trailing pad word count derives from n, the number of data words, n = (count + offset + 3) / 4. Mode 1 adds (-n) mod 4 pad words, mode 2 adds (-n) mod 8, and modes 0 and 3 add none.
- R5: A buffer without the first-segment flag leaves the tag and the length unchanged: its bytes follow the earlier ones, and its second command word is consumed but not used. A buffer without the last-segment flag produces no strobe and no status entry.
- R6: doneFlag is high for one cycle at the end of every buffer whose bit 31 is set, and it stays low at the end of a buffer whose bit 31 is clear.
- R7: Bytes that would land at or beyond PKT_BYTES are dropped, and txErrFlag is high for one cycle after any data word that lost a byte. The length stops at PKT_BYTES.
- R8: Every first command word, every second command word of a first segment, and every data or pad word that is not a whole-offset skip counts against a budget of FIFO_WORDS. The budget resets when a frame is sent. A write made when the budget is used up is ignored and pulses overrunFlag.
- R9: A completed frame pushes bits 31:16 of its second command word into the status FIFO. statusData shows the oldest entry, and statusPop removes it.
- R10: A frame that completes while the status FIFO holds STATUS_DEPTH entries still strobes sendValid, but it adds no entry and does not pulse statusFullFlag. statusFullFlag pulses for one cycle when an accepted push brings the count to STATUS_DEPTH.
- R11: statusLevelFlag pulses for one cycle when an accepted push leaves the count greater than statusLevel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrValid | input | 1 | Host write to the transmit data port |
| wrData | input | 32 | Write word: command or data |
| statusLevel | input | 8 | Status fill level threshold |
| statusPop | input | 1 | Remove the oldest status entry |
| statusData | output | 16 | Oldest queued packet tag |
| statusCount | output | $clog2(STATUS_DEPTH+1) | Status entries held |
| sendValid | output | 1 | One-cycle frame send strobe |
| sendLen | output | $clog2(PKT_BYTES+1) | Frame byte length, valid with sendValid |
| pktRdAddr | input | $clog2(PKT_BYTES) | Packet store read address |
| pktRdData | output | 8 | Packet store byte at pktRdAddr |
| doneFlag | output | 1 | Completion request seen at buffer end |
| txErrFlag | output | 1 | Bytes dropped, packet store full |
| overrunFlag | output | 1 | Write refused, word budget used up |
| statusLevelFlag | output | 1 | Status fill above statusLevel |
| statusFullFlag | output | 1 | Status FIFO just became full |

## Verification
The properties assume that every buffer is at least a first command word, a second command word and one data word. This keeps two send strobes from ever arriving on neighbouring cycles. They also assume that statusPop is raised only at times when no frame is completing, so a count increase can be traced to a send. The stimulus writes only complete, well-formed buffers with nonzero byte counts. It pulses statusPop only between buffers and holds statusLevel steady while any frame is in flight.

// File: rtl/txa_pkg.sv
`timescale 1ns/1ps
package txa_pkg;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMDB = 2'd1,
    S_DATA = 2'd2
  } parse_state_t;

  // control -> datapath strobes, one write at a time
  typedef struct packed {
    logic        take;      // data word carries payload bytes
    logic [1:0]  skip;      // low bytes to drop from this word
    logic [2:0]  nBytes;    // payload bytes in this word (0..4)
    logic        clearLen;  // restart the frame length
    logic        send;      // frame complete
    logic [15:0] tag;       // tag to queue with the send
  } strobe_t;

endpackage

// File: rtl/txa_ctrl.sv
`timescale 1ns/1ps
module txa_ctrl
  import txa_pkg::*;
#(
  parameter int FIFO_WORDS = 1152,
  localparam int UW = $clog2(FIFO_WORDS + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  output strobe_t     strobe,
  output logic        doneFlag,
  output logic        overrunFlag
);

  parse_state_t state, nState;
  logic [11:0]   bufLeft, nBuf;
  logic [4:0]    offs, nOffs;
  logic          first, nFirst, last, nLast, ioc, nIoc;
  logic [1:0]    mode, nMode;
  logic [2:0]    pad, nPad;
  logic [15:0]   tag, nTag;
  logic [UW-1:0] used, nUsed;
  logic          doneNxt, ovrNxt;

  logic [12:0] avail, words, negWords;
  logic [2:0]  takeCnt, nb;
  logic        unusedCmdBits;

  assign unusedCmdBits = ^{wrData[15:14], wrData[11]};

  always_comb begin
    avail    = 13'(bufLeft) + 13'(offs);
    words    = (avail + 13'd3) >> 2;
    negWords = 13'd0 - words;
    takeCnt  = (avail >= 13'd4) ? 3'd4 : avail[2:0];
    nb       = takeCnt - {1'b0, offs[1:0]};
  end

  always_comb begin
    nState = state;  nBuf = bufLeft; nOffs = offs;
    nFirst = first;  nLast = last;   nIoc = ioc;  nMode = mode;
    nPad = pad;      nTag = tag;     nUsed = used;
    doneNxt = 1'b0;  ovrNxt = 1'b0;
    strobe = '0;
    strobe.tag = tag;
    if (wrValid) begin
      if (used == UW'(FIFO_WORDS)) begin
        ovrNxt = 1'b1;
      end else begin
        unique case (state)
          S_IDLE: begin
            nBuf   = {1'b0, wrData[10:0]};
            nOffs  = wrData[20:16];
            nFirst = wrData[13];
            nLast  = wrData[12];
            nIoc   = wrData[31];
            nMode  = wrData[25:24];
            nUsed  = used + 1'b1;
            nState = S_CMDB;
          end
          S_CMDB: begin
            if (first) begin
              nTag = wrData[31:16];
              nUsed = used + 1'b1;
              strobe.clearLen = 1'b1;
              nPad = (mode == 2'd1) ? {1'b0, negWords[1:0]} :
                     (mode == 2'd2) ? negWords[2:0] : 3'd0;
            end
            nState = S_DATA;
          end
          S_DATA: begin
            if (offs >= 5'd4) begin
              nOffs = offs - 5'd4;
            end else begin
              if (bufLeft == 12'd0 && pad != 3'd0) begin
                nPad = pad - 3'd1;
              end else begin
                strobe.take   = 1'b1;
                strobe.skip   = offs[1:0];
                strobe.nBytes = nb;
                nBuf  = bufLeft - 12'(nb);
                nOffs = 5'd0;
              end
              nUsed = used + 1'b1;
              if (nBuf == 12'd0 && nPad == 3'd0) begin
                nState  = S_IDLE;
                doneNxt = ioc;
                if (last) begin
                  strobe.send = 1'b1;
                  nUsed = '0;
                end
              end
            end
          end
          default: nState = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bufLeft <= '0; offs <= '0;
      first <= 1'b0; last <= 1'b0; ioc <= 1'b0; mode <= '0;
      pad <= '0; tag <= '0; used <= '0;
      doneFlag <= 1'b0; overrunFlag <= 1'b0;
    end else begin
      state <= nState; bufLeft <= nBuf; offs <= nOffs;
      first <= nFirst; last <= nLast; ioc <= nIoc; mode <= nMode;
      pad <= nPad; tag <= nTag; used <= nUsed;
      doneFlag <= doneNxt; overrunFlag <= ovrNxt;
    end
  end

endmodule

// File: rtl/txa_pktbuf.sv
`timescale 1ns/1ps
module txa_pktbuf
  import txa_pkg::*;
#(
  parameter int PKT_BYTES = 2048,
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int AW = $clog2(PKT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   wrData,
  input  strobe_t       strobe,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          sendValid,
  output logic [LW-1:0] sendLen,
  output logic          txErrFlag
);

  logic [7:0]    mem [PKT_BYTES];
  logic [LW-1:0] lenReg;
  logic [LW-1:0] idx [4];
  logic [3:0]    keep;
  logic [7:0]    laneByte [4];
  logic [2:0]    stored;
  logic          over;

  for (genvar k = 0; k < 4; k++) begin : gLane
    assign idx[k]      = lenReg + LW'(k);
    assign keep[k]     = strobe.take && (3'(k) < strobe.nBytes) && (idx[k] < LW'(PKT_BYTES));
    assign laneByte[k] = wrData[{strobe.skip + 2'(k), 3'b000} +: 8];
  end

  always_comb begin
    stored = '0;
    for (int k = 0; k < 4; k++) stored = stored + 3'(keep[k]);
    over = strobe.take &&
           (({1'b0, lenReg} + (LW+1)'(strobe.nBytes)) > (LW+1)'(PKT_BYTES));
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (keep[k]) mem[idx[k][AW-1:0]] <= laneByte[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenReg <= '0; sendValid <= 1'b0; txErrFlag <= 1'b0;
    end else begin
      if (strobe.clearLen)  lenReg <= '0;
      else if (strobe.take) lenReg <= lenReg + LW'(stored);
      sendValid <= strobe.send;
      txErrFlag <= over;
    end
  end

  assign sendLen = lenReg;
  assign rdData  = mem[rdAddr];

endmodule

// File: rtl/txa_statfifo.sv
`timescale 1ns/1ps
module txa_statfifo #(
  parameter int STATUS_DEPTH = 512,
  localparam int CW = $clog2(STATUS_DEPTH + 1),
  localparam int PW = $clog2(STATUS_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [15:0]   tagIn,
  input  logic          pop,
  input  logic [7:0]    level,
  output logic [15:0]   headTag,
  output logic [CW-1:0] count,
  output logic          fullFlag,
  output logic          levelFlag
);

  logic [15:0]   mem [STATUS_DEPTH];
  logic [PW-1:0] head, tail;
  logic          doPush, doPop;
  logic [CW-1:0] countUp;

  assign doPush  = push && (count != CW'(STATUS_DEPTH));
  assign doPop   = pop && (count != '0);
  assign countUp = count + 1'b1;

  always_ff @(posedge clk) begin
    if (doPush) mem[tail] <= tagIn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0; tail <= '0; count <= '0;
      fullFlag <= 1'b0; levelFlag <= 1'b0;
    end else begin
      if (doPush) tail <= (tail == PW'(STATUS_DEPTH - 1)) ? '0 : tail + 1'b1;
      if (doPop)  head <= (head == PW'(STATUS_DEPTH - 1)) ? '0 : head + 1'b1;
      count     <= count + CW'(doPush) - CW'(doPop);
      fullFlag  <= doPush && (countUp == CW'(STATUS_DEPTH));
      levelFlag <= doPush && ((CW+8)'(countUp) > (CW+8)'(level));
    end
  end

  assign headTag = mem[head];

endmodule

// File: rtl/tx_pkt_assembler.sv
`timescale 1ns/1ps
module tx_pkt_assembler
  import txa_pkg::*;
#(
  parameter int PKT_BYTES    = 2048,
  parameter int STATUS_DEPTH = 512,
  parameter int FIFO_WORDS   = 1152,
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int AW = $clog2(PKT_BYTES),
  localparam int CW = $clog2(STATUS_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrValid,
  input  logic [31:0]   wrData,
  input  logic [7:0]    statusLevel,
  input  logic          statusPop,
  output logic [15:0]   statusData,
  output logic [CW-1:0] statusCount,
  output logic          sendValid,
  output logic [LW-1:0] sendLen,
  input  logic [AW-1:0] pktRdAddr,
  output logic [7:0]    pktRdData,
  output logic          doneFlag,
  output logic          txErrFlag,
  output logic          overrunFlag,
  output logic          statusLevelFlag,
  output logic          statusFullFlag
);

  strobe_t strobe;

  txa_ctrl #(.FIFO_WORDS(FIFO_WORDS)) uCtrl (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .strobe(strobe), .doneFlag(doneFlag), .overrunFlag(overrunFlag)
  );

  txa_pktbuf #(.PKT_BYTES(PKT_BYTES)) uBuf (
    .clk(clk), .rst_n(rst_n), .wrData(wrData), .strobe(strobe),
    .rdAddr(pktRdAddr), .rdData(pktRdData),
    .sendValid(sendValid), .sendLen(sendLen), .txErrFlag(txErrFlag)
  );

  txa_statfifo #(.STATUS_DEPTH(STATUS_DEPTH)) uStat (
    .clk(clk), .rst_n(rst_n), .push(strobe.send), .tagIn(strobe.tag),
    .pop(statusPop), .level(statusLevel), .headTag(statusData),
    .count(statusCount), .fullFlag(statusFullFlag), .levelFlag(statusLevelFlag)
  );

endmodule

// File: rtl/txa_checker.sv
`timescale 1ns/1ps
module txa_checker #(
  parameter int PKT_BYTES    = 2048,
  parameter int STATUS_DEPTH = 512,
  localparam int LW = $clog2(PKT_BYTES + 1),
  localparam int CW = $clog2(STATUS_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sendValid,
  input logic [LW-1:0] sendLen,
  input logic [CW-1:0] statusCount,
  input logic          statusFullFlag,
  input logic          statusLevelFlag,
  input logic          overrunFlag
);

  logic pastValid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pastValid <= 1'b0;
    else        pastValid <= 1'b1;
  end

  assert_send_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sendValid |=> !sendValid);

  assert_len_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sendValid |-> (sendLen <= LW'(PKT_BYTES)));

  assert_refused_no_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrunFlag |-> !sendValid);

  assert_count_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pastValid && (statusCount > $past(statusCount))) |-> sendValid);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    statusCount <= CW'(STATUS_DEPTH));

  assert_full_at_depth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    statusFullFlag |-> (sendValid && statusCount == CW'(STATUS_DEPTH)));

  assert_level_on_send_R11: assert property (@(posedge clk) disable iff (!rst_n)
    statusLevelFlag |-> sendValid);

endmodule

bind tx_pkt_assembler txa_checker #(
  .PKT_BYTES(PKT_BYTES), .STATUS_DEPTH(STATUS_DEPTH)
) uChk (
  .clk(clk), .rst_n(rst_n), .sendValid(sendValid), .sendLen(sendLen),
  .statusCount(statusCount), .statusFullFlag(statusFullFlag),
  .statusLevelFlag(statusLevelFlag), .overrunFlag(overrunFlag)
);

// File: tb/tx_pkt_assembler_test.sv
`timescale 1ns/1ps
module tx_pkt_assembler_test;

  localparam int PKT  = 2048;
  localparam int DEP  = 512;
  localparam int BUDG = 1152;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [7:0]  statusLevel = 8'd1;
  logic        statusPop = 1'b0;
  logic [15:0] statusData;
  logic [9:0]  statusCount;
  logic        sendValid;
  logic [11:0] sendLen;
  logic [10:0] pktRdAddr = '0;
  logic [7:0]  pktRdData;
  logic        doneFlag, txErrFlag, overrunFlag, statusLevelFlag, statusFullFlag;

  tx_pkt_assembler uut (
    .clk(clk), .rst_n(rst_n), .wrValid(wrValid), .wrData(wrData),
    .statusLevel(statusLevel), .statusPop(statusPop), .statusData(statusData),
    .statusCount(statusCount), .sendValid(sendValid), .sendLen(sendLen),
    .pktRdAddr(pktRdAddr), .pktRdData(pktRdData), .doneFlag(doneFlag),
    .txErrFlag(txErrFlag), .overrunFlag(overrunFlag),
    .statusLevelFlag(statusLevelFlag), .statusFullFlag(statusFullFlag)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int seed = 0;
  int expLen = 0;
  logic [7:0] expBuf [PKT];
  int lenQ [$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every send strobe must match the next expected length
  always @(negedge clk) begin
    if (rst_n && sendValid) begin
      if (lenQ.size() == 0) chk(1'b0, "R2 unexpected send", sendLen, 0);
      else begin
        int e;
        e = lenQ.pop_front();
        chk(sendLen == 12'(e), "R2 send length", sendLen, e);
      end
    end
  end

  task automatic doReset();
    rst_n = 1'b0; wrValid = 1'b0; statusPop = 1'b0;
    lenQ.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [31:0] w);
    wrValid = 1'b1; wrData = w;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic popStatus();
    statusPop = 1'b1;
    @(negedge clk);
    statusPop = 1'b0;
  endtask

  function automatic logic [31:0] mkCmdA(input bit ioc, input logic [1:0] mode,
      input logic [4:0] offs, input bit first, input bit last, input logic [10:0] size);
    return {ioc, 5'b0, mode, 3'b0, offs, 2'b0, first, last, 1'b0, size};
  endfunction

  function automatic logic [7:0] payByte(input int s, input int i);
    return 8'(s * 37 + i * 5 + 1);
  endfunction

  task automatic sendBuffer(input bit first, input bit last, input bit ioc,
      input logic [1:0] mode, input int offs, input int size,
      input logic [15:0] tag, input string req);
    int words, padW, predLen;
    words = (size + offs + 3) / 4;
    padW  = (mode == 2'd1) ? (4 - words % 4) % 4 :
            (mode == 2'd2) ? (8 - words % 8) % 8 : 0;
    seed++;
    predLen = first ? size : expLen + size;
    if (predLen > PKT) predLen = PKT;
    if (last) lenQ.push_back(predLen);
    if (first) expLen = 0;
    writeWord(mkCmdA(ioc, mode, 5'(offs), first, last, 11'(size)));
    chk(sendValid == 1'b0, req, sendValid, 0);
    writeWord({tag, 16'h5A5A});
    chk(sendValid == 1'b0, req, sendValid, 0);
    for (int w = 0; w < words; w++) begin
      logic [31:0] word;
      int nbThis;
      bit expErr;
      nbThis = 0;
      for (int b = 0; b < 4; b++) begin
        int slot;
        slot = w * 4 + b;
        if (slot < offs) word[8*b +: 8] = 8'hEE;
        else if (slot < offs + size) begin
          word[8*b +: 8] = payByte(seed, slot - offs);
          nbThis++;
        end else word[8*b +: 8] = 8'h77;
      end
      expErr = (expLen + nbThis > PKT) && (nbThis > 0);
      for (int b = 0; b < 4; b++) begin
        int slot;
        slot = w * 4 + b;
        if (slot >= offs && slot < offs + size && expLen < PKT) begin
          expBuf[expLen] = payByte(seed, slot - offs);
          expLen++;
        end
      end
      writeWord(word);
      chk(txErrFlag == expErr, "R7 byte loss flag", txErrFlag, expErr);
      if (!(w == words - 1 && padW == 0))
        chk(sendValid == 1'b0, {req, " early send"}, sendValid, 0);
    end
    for (int p = 0; p < padW; p++) begin
      writeWord(32'hDEADBEEF);
      if (p != padW - 1) chk(sendValid == 1'b0, "R4 pad early send", sendValid, 0);
    end
    chk(doneFlag == ioc, "R6 completion flag", doneFlag, ioc);
    chk(sendValid == last, {req, " send at buffer end"}, sendValid, last);
  endtask

  task automatic checkBytes(input string req);
    int bad, firstBad;
    logic [7:0] act;
    bad = 0; firstBad = -1; act = '0;
    for (int i = 0; i < expLen; i++) begin
      pktRdAddr = 11'(i);
      #1;
      if (pktRdData !== expBuf[i]) begin
        if (firstBad < 0) begin firstBad = i; act = pktRdData; end
        bad++;
      end
    end
    if (firstBad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, {req, " packet byte"}, act, expBuf[firstBad]);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    bit anyOvr, anyFull;
    doReset();
    // R1 reset state
    chk(sendValid == 1'b0, "R1 sendValid", sendValid, 0);
    chk(statusCount == 10'd0, "R1 status count", statusCount, 0);
    chk({doneFlag, txErrFlag, overrunFlag, statusLevelFlag, statusFullFlag} == 5'b0,
        "R1 flags", {doneFlag, txErrFlag, overrunFlag, statusLevelFlag, statusFullFlag}, 0);

    // R2/R3/R6: single buffer, no offset, no pad
    sendBuffer(1, 1, 1, 2'd0, 0, 10, 16'h1234, "R2");
    chk(statusLevelFlag == 1'b0, "R11 count 1 not above level 1", statusLevelFlag, 0);
    checkBytes("R3 plain");
    chk(statusCount == 10'd1, "R9 count", statusCount, 1);
    chk(statusData == 16'h1234, "R9 tag", statusData, 16'h1234);

    // R3/R4: offset with a whole skipped word, mode 1 pad
    sendBuffer(1, 1, 0, 2'd1, 6, 5, 16'h2222, "R4 mode1");
    chk(statusLevelFlag == 1'b1, "R11 count 2 above level 1", statusLevelFlag, 1);
    checkBytes("R3 offset 6");

    // R4: mode 2 pad, offset 1
    sendBuffer(1, 1, 0, 2'd2, 1, 4, 16'h3333, "R4 mode2");
    checkBytes("R3 offset 1");

    // R5: two-segment frame
    sendBuffer(1, 0, 0, 2'd0, 2, 5, 16'hAAAA, "R5 first seg");
    chk(statusCount == 10'd3, "R5 no entry for non-last", statusCount, 3);
    sendBuffer(0, 1, 1, 2'd0, 3, 6, 16'hBBBB, "R5 last seg");
    checkBytes("R5 concatenated");
    chk(statusCount == 10'd4, "R5 count", statusCount, 4);

    // R9: FIFO order
    chk(statusData == 16'h1234, "R9 head 0", statusData, 16'h1234);
    popStatus();
    chk(statusData == 16'h2222, "R9 head 1", statusData, 16'h2222);
    popStatus();
    chk(statusData == 16'h3333, "R9 head 2", statusData, 16'h3333);
    popStatus();
    chk(statusData == 16'hAAAA, "R5 tag from first segment", statusData, 16'hAAAA);
    popStatus();
    chk(statusCount == 10'd0, "R9 drained", statusCount, 0);

    // R7: packet store overflow
    sendBuffer(1, 0, 0, 2'd0, 0, 2047, 16'h0E0E, "R7 fill");
    sendBuffer(0, 1, 0, 2'd0, 0, 8, 16'h0F0F, "R7 spill");
    checkBytes("R7 stored bytes");
    chk(lenQ.size() == 0, "R2 all sends seen", lenQ.size(), 0);

    // R8: word budget overrun
    doReset();
    writeWord(mkCmdA(0, 2'd0, 5'd0, 1, 0, 11'd2044));
    writeWord(32'h0);
    for (int i = 0; i < 511; i++) writeWord(32'h11111111);
    writeWord(mkCmdA(0, 2'd0, 5'd0, 0, 0, 11'd2044));
    writeWord(32'h0);
    for (int i = 0; i < 511; i++) writeWord(32'h22222222);
    writeWord(mkCmdA(0, 2'd0, 5'd0, 0, 1, 11'd2044));
    writeWord(32'h0);
    anyOvr = 1'b0;
    for (int i = 0; i < 126; i++) begin
      writeWord(32'h33333333);
      if (overrunFlag) anyOvr = 1'b1;
    end
    chk(anyOvr == 1'b0, "R8 no overrun within budget", anyOvr, 0);
    writeWord(32'h44444444);
    chk(overrunFlag == 1'b1, "R8 overrun at budget", overrunFlag, 1);
    for (int i = 0; i < 400; i++) writeWord(32'h55555555);
    chk(overrunFlag == 1'b1 && sendValid == 1'b0, "R8 refused writes ignored",
        {overrunFlag, sendValid}, 2'b10);
    chk(statusCount == 10'd0, "R8 no frame completed", statusCount, 0);

    // R10: status FIFO full and drop
    doReset();
    statusLevel = 8'd255;
    anyOvr = 1'b0; anyFull = 1'b0;
    for (int i = 0; i < DEP - 1; i++) begin
      sendBuffer(1, 1, 0, 2'd0, 0, 1, 16'(16'h0100 + i), "R10 fill");
      if (statusFullFlag) anyFull = 1'b1;
      if (overrunFlag) anyOvr = 1'b1;
    end
    chk(anyFull == 1'b0, "R10 no full flag early", anyFull, 0);
    chk(anyOvr == 1'b0, "R8 budget resets on send", anyOvr, 0);
    sendBuffer(1, 1, 0, 2'd0, 0, 1, 16'h02FF, "R10 last slot");
    chk(statusFullFlag == 1'b1, "R10 full flag", statusFullFlag, 1);
    chk(statusCount == 10'(DEP), "R10 count at depth", statusCount, DEP);
    sendBuffer(1, 1, 0, 2'd0, 0, 1, 16'h0BAD, "R10 dropped");
    chk(statusFullFlag == 1'b0, "R10 no flag on drop", statusFullFlag, 0);
    chk(statusCount == 10'(DEP), "R10 count unchanged", statusCount, DEP);
    chk(statusData == 16'h0100, "R9 oldest after fill", statusData, 16'h0100);
    popStatus();
    chk(statusData == 16'h0101, "R9 next after pop", statusData, 16'h0101);
    chk(statusCount == 10'(DEP - 1), "R9 count after pop", statusCount, DEP - 1);
    chk(lenQ.size() == 0, "R2 all sends seen", lenQ.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule